// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block turns one pixel-rate clock into the timing grid of a fixed-format raster display. A horizontal position counter steps on every clock and wraps at the end of a scanline. A scanline counter steps on each horizontal wrap and wraps at the end of a frame. From these two positions the block drives an active-low horizontal sync, an active-low vertical (composite) sync, and a flag that marks the visible picture window. Downstream fetch and pixel logic use these outputs as their coordinate source.

The vertical sync is released halfway along a scanline rather than at a line boundary. A frame flag is raised when the first scanline after the picture begins, and is dropped at the start of the next frame. Software can also clear it early with an acknowledge pulse. All geometry is fixed at elaboration through parameters. The defaults describe a 1024-clock line and a 312-line frame, with a 640 by 256 picture.

Top module: `raster_timing_gen`

## Requirements
- R1: `pos_x_o` steps by one on every clock and wraps from LINE_LEN-1 to 0. `pos_y_o` steps by one on each such wrap and wraps from FRAME_LINES-1 to 0. Both hold their value at any other time.
- R2: `hsync_no` is 0 while `pos_x_o` is below HS_END (default 75) and 1 otherwise, on every line.
- R3: `vsync_no` is 0 from position (x=0, y=0) until just before (x=VS_END_POS, y=VS_END_LINE), with defaults 512 and 2. It is 1 from that point on, to the end of the frame.
- R4: `active_o` is 1 exactly when `pos_y_o` lies in [ACT_Y0, ACT_Y0+ACT_LINES-1] and `pos_x_o` lies in [ACT_X0, ACT_X0+ACT_W-1]. The defaults are lines 38..293 and positions 256..895.
- R5: `frame_irq_o` becomes 1 in the cycle in which the position is (x=0, y=ACT_Y0+ACT_LINES). It becomes 0 in the cycle in which the position is (0, 0). It holds its value otherwise.
- R6: `irq_ack_i` sampled high at a clock edge makes `frame_irq_o` 0 after that edge. When the flag is already 0, it has no effect.
- R7: If the edge that moves the position to the set point also samples `irq_ack_i` high, `frame_irq_o` is 1 after it, because set wins.
- R8: While `rst_ni` is 0, both counters are 0, both syncs are 1, and `active_o` and `frame_irq_o` are 0. The first edge after release moves to x=1 and follows R1 to R7 from there.
- R9: All outputs are registers updated on the same edge, so every sync, window and flag value matches the `pos_x_o`/`pos_y_o` shown in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ack_i | input | 1 | Clears the frame flag |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical/composite sync, active low |
| pos_x_o | output | $clog2(LINE_LEN) | Horizontal position |
| pos_y_o | output | $clog2(FRAME_LINES) | Scanline number |
| active_o | output | 1 | Inside picture window |
| frame_irq_o | output | 1 | End-of-picture frame flag |

## Verification
Every output is registered from the next-position logic, so each result is due on the very edge that moves the counters to the position it belongs to. There is no added latency, and an acknowledge sampled at one edge is visible right after that edge. The bench uses a reduced geometry. It steps a position model at each rising edge, using the acknowledge value it drove beforehand. It then compares all outputs against that model at the following falling edge, on every cycle of several frames. This also covers the same-edge collision of acknowledge and set, and a reset applied mid-frame.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;
  localparam int DEF_LINE_LEN    = 1024;
  localparam int DEF_FRAME_LINES = 312;
  localparam int DEF_HS_END      = 75;
  localparam int DEF_VS_END_LINE = 2;
  localparam int DEF_VS_END_POS  = 512;
  localparam int DEF_ACT_Y0      = 38;
  localparam int DEF_ACT_LINES   = 256;
  localparam int DEF_ACT_X0      = 256;
  localparam int DEF_ACT_W       = 640;
endpackage

// File: rtl/raster_wrap_counter.sv
module raster_wrap_counter #(
  parameter int MOD = 1024,
  localparam int W = $clog2(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         last_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  assign last_o = (cnt_o == LAST);

  always_comb begin
    cnt_nxt_o = cnt_o;
    if (step_i) cnt_nxt_o = last_o ? '0 : cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_nxt_o;
  end

  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_o == LAST) |=> (cnt_o == '0));
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_o));
endmodule

// File: rtl/raster_sync_decode.sv
module raster_sync_decode #(
  parameter int XW          = 10,
  parameter int YW          = 9,
  parameter int HS_END      = 75,
  parameter int VS_END_LINE = 2,
  parameter int VS_END_POS  = 512,
  parameter int ACT_Y0      = 38,
  parameter int ACT_LINES   = 256,
  parameter int ACT_X0      = 256,
  parameter int ACT_W       = 640
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [XW-1:0] x_nxt_i,
  input  logic [YW-1:0] y_nxt_i,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          active_o
);
  localparam logic [XW-1:0] HS_X   = XW'(HS_END);
  localparam logic [YW-1:0] VS_Y   = YW'(VS_END_LINE);
  localparam logic [XW-1:0] VS_X   = XW'(VS_END_POS);
  localparam logic [YW-1:0] AY_LO  = YW'(ACT_Y0);
  localparam logic [YW-1:0] AY_HI  = YW'(ACT_Y0 + ACT_LINES - 1);
  localparam logic [XW-1:0] AX_LO  = XW'(ACT_X0);
  localparam logic [XW-1:0] AX_HI  = XW'(ACT_X0 + ACT_W - 1);

  logic hs_low, vs_low, in_win;

  always_comb begin
    hs_low = (x_nxt_i < HS_X);
    // vsync released mid-line at VS_X of line VS_Y
    vs_low = (y_nxt_i < VS_Y) || ((y_nxt_i == VS_Y) && (x_nxt_i < VS_X));
    in_win = (y_nxt_i >= AY_LO) && (y_nxt_i <= AY_HI) &&
             (x_nxt_i >= AX_LO) && (x_nxt_i <= AX_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_no <= 1'b1;
      vsync_no <= 1'b1;
      active_o <= 1'b0;
    end else begin
      hsync_no <= !hs_low;
      vsync_no <= !vs_low;
      active_o <= in_win;
    end
  end
endmodule

// File: rtl/raster_frame_flag.sv
module raster_frame_flag #(
  parameter int XW       = 10,
  parameter int YW       = 9,
  parameter int SET_LINE = 294
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [XW-1:0] x_nxt_i,
  input  logic [YW-1:0] y_nxt_i,
  input  logic          ack_i,
  output logic          flag_o
);
  localparam logic [YW-1:0] SET_Y = YW'(SET_LINE);

  logic hit_set, hit_clr;
  assign hit_set = (x_nxt_i == '0) && (y_nxt_i == SET_Y);
  assign hit_clr = (x_nxt_i == '0) && (y_nxt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_o <= 1'b0;
    else if (hit_set)           flag_o <= 1'b1;  // set beats acknowledge
    else if (hit_clr || ack_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_timing_pkg::*;
#(
  parameter int LINE_LEN    = DEF_LINE_LEN,
  parameter int FRAME_LINES = DEF_FRAME_LINES,
  parameter int HS_END      = DEF_HS_END,
  parameter int VS_END_LINE = DEF_VS_END_LINE,
  parameter int VS_END_POS  = DEF_VS_END_POS,
  parameter int ACT_Y0      = DEF_ACT_Y0,
  parameter int ACT_LINES   = DEF_ACT_LINES,
  parameter int ACT_X0      = DEF_ACT_X0,
  parameter int ACT_W       = DEF_ACT_W,
  localparam int XW = $clog2(LINE_LEN),
  localparam int YW = $clog2(FRAME_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_ack_i,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic [XW-1:0] pos_x_o,
  output logic [YW-1:0] pos_y_o,
  output logic          active_o,
  output logic          frame_irq_o
);
  localparam int IRQ_LINE = ACT_Y0 + ACT_LINES;
  localparam logic [XW-1:0] X_LAST = XW'(LINE_LEN - 1);
  localparam logic [XW-1:0] HS_X   = XW'(HS_END);
  localparam logic [YW-1:0] VS_Y   = YW'(VS_END_LINE);
  localparam logic [XW-1:0] VS_X   = XW'(VS_END_POS);
  localparam logic [YW-1:0] IRQ_Y  = YW'(IRQ_LINE);

  logic [XW-1:0] x_nxt;
  logic [YW-1:0] y_nxt;
  logic          x_last, y_last;

  raster_wrap_counter #(.MOD(LINE_LEN)) u_hcnt (
    .clk_i, .rst_ni, .step_i(1'b1),
    .cnt_o(pos_x_o), .cnt_nxt_o(x_nxt), .last_o(x_last)
  );

  raster_wrap_counter #(.MOD(FRAME_LINES)) u_vcnt (
    .clk_i, .rst_ni, .step_i(x_last),
    .cnt_o(pos_y_o), .cnt_nxt_o(y_nxt), .last_o(y_last)
  );

  raster_sync_decode #(
    .XW(XW), .YW(YW), .HS_END(HS_END), .VS_END_LINE(VS_END_LINE),
    .VS_END_POS(VS_END_POS), .ACT_Y0(ACT_Y0), .ACT_LINES(ACT_LINES),
    .ACT_X0(ACT_X0), .ACT_W(ACT_W)
  ) u_sync (
    .clk_i, .rst_ni, .x_nxt_i(x_nxt), .y_nxt_i(y_nxt),
    .hsync_no, .vsync_no, .active_o
  );

  raster_frame_flag #(.XW(XW), .YW(YW), .SET_LINE(IRQ_LINE)) u_flag (
    .clk_i, .rst_ni, .x_nxt_i(x_nxt), .y_nxt_i(y_nxt),
    .ack_i(irq_ack_i), .flag_o(frame_irq_o)
  );

  assert_line_adv_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_last && !y_last) |=> (pos_y_o == $past(pos_y_o) + 1'b1));
  assert_frame_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_last && y_last) |=> (pos_y_o == '0));
  assert_hs_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_x_o == HS_X) |-> hsync_no);
  assert_hs_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_x_o == XW'(1)) |-> !hsync_no);
  assert_vs_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_y_o == VS_Y && pos_x_o == VS_X) |-> vsync_no);
  assert_vs_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_no) |-> (pos_y_o == VS_Y && pos_x_o == VS_X));
  assert_win_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (pos_x_o >= XW'(ACT_X0) && pos_y_o >= YW'(ACT_Y0)));
  assert_irq_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_x_o == '0 && pos_y_o == IRQ_Y) |-> frame_irq_o);
  assert_irq_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_x_o == '0 && pos_y_o == '0) |-> !frame_irq_o);
  assert_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !(x_last && pos_y_o == IRQ_Y - 1'b1)) |=> !frame_irq_o);
  assert_ack_lose_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_last && pos_y_o == IRQ_Y - 1'b1) |=> frame_irq_o);
  assert_x_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_last |=> (pos_x_o == $past(pos_x_o) + 1'b1));
endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
  localparam int LN = 32, FL = 12, HE = 5, VL = 2, VP = 16;
  localparam int AY = 3, AL = 6, AX = 8, AW = 20;
  localparam int IRQL = AY + AL;

  logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0;
  logic hs_n, vs_n, act, irq;
  logic [4:0] px;
  logic [3:0] py;

  raster_timing_gen #(
    .LINE_LEN(LN), .FRAME_LINES(FL), .HS_END(HE), .VS_END_LINE(VL),
    .VS_END_POS(VP), .ACT_Y0(AY), .ACT_LINES(AL), .ACT_X0(AX), .ACT_W(AW)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_ack_i(ack), .hsync_no(hs_n),
    .vsync_no(vs_n), .pos_x_o(px), .pos_y_o(py), .active_o(act),
    .frame_irq_o(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int mx = 0, my = 0;
  bit mirq = 0, fresh = 1;

  task automatic chk(string tag, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s at x=%0d y=%0d: actual=%0d expected=%0d", tag, mx, my, actual, expected);
    end
  endtask

  task automatic check_all();
    int ehs, evs, eact;
    ehs  = fresh ? 1 : (mx >= HE);
    evs  = fresh ? 1 : !((my < VL) || (my == VL && mx < VP));
    eact = (my >= AY && my < AY + AL && mx >= AX && mx < AX + AW);
    chk("R1 pos_x", int'(px), mx);
    chk("R1 pos_y", int'(py), my);
    chk("R2 hsync", int'(hs_n), ehs);
    chk("R3 vsync", int'(vs_n), evs);
    chk("R4 active", int'(act), eact);
    chk("R5 irq", int'(irq), int'(mirq));
  endtask

  // at a negedge: drive ack, take one rising edge, check at next negedge
  task automatic step(bit a);
    ack = a;
    @(posedge clk);
    if (rst_n) begin
      fresh = 0;
      mx = (mx == LN - 1) ? 0 : mx + 1;
      if (mx == 0) my = (my == FL - 1) ? 0 : my + 1;
      if (mx == 0 && my == IRQL) mirq = 1;
      else if ((mx == 0 && my == 0) || a) mirq = 0;
    end
    @(negedge clk);
    ack = 1'b0;
    check_all();
  endtask

  task automatic run_to(int tx, int ty);
    int guard = 0;
    while (!(mx == tx && my == ty) && guard < 4 * LN * FL) begin
      step(1'b0);
      guard++;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all(); // R8 reset state
    rst_n = 1'b1;
    // R1..R5: one and a half frames without acknowledge
    for (int i = 0; i < LN * FL + LN * FL / 2; i++) step(1'b0);
    // R6: acknowledge while the flag is high
    run_to(3, IRQL);
    chk("R6 flag high before ack", int'(irq), 1);
    step(1'b1);
    chk("R6 flag cleared by ack", int'(irq), 0);
    // R6: acknowledge while low has no effect
    step(1'b1);
    chk("R6 ack on low flag", int'(irq), 0);
    // R7: acknowledge on the set edge
    run_to(LN - 1, IRQL - 1);
    step(1'b1);
    chk("R7 set wins over ack", int'(irq), 1);
    for (int i = 0; i < LN * FL; i++) step(1'b0);
    // R8: reset mid-frame
    run_to(10, AY + 1);
    rst_n = 1'b0;
    #1;
    mx = 0; my = 0; mirq = 0; fresh = 1;
    check_all();
    step(1'b0);
    step(1'b1);
    chk("R8 held in reset x", int'(px), 0);
    rst_n = 1'b1;
    step(1'b0);
    chk("R8 first step after release", int'(px), 1);
    // R9: another full frame, every output aligned with positions
    for (int i = 0; i < LN * FL + 4; i++) step(1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule